// File: doc/BRIEF.md
# Instruction Decoder and Next-PC Unit

This block takes one 32-bit instruction word together with the register values it names, the current program counter and the saved exception-return value. It splits the word into its fields and produces the operand C value, which is either a register or the zero-extended immediate. For control-flow instructions it works out where the program goes next. The fields are a 2-bit group, an immediate flag, a 3-bit operation, three 5-bit register indices and a 16-bit immediate.

For the flow group, the unit evaluates signed compare-and-branch conditions on operands A and B. It also handles an absolute jump-on-equal, a call that writes a link value and an exception return, and it reports which of these need an extra cycle. It raises a trap request for the reserved flow operation and asserts a re-enable for interrupt queue handling on exception return. For every other group the next PC is simply the incremented PC.

All results are registered, so they appear one clock after the input is accepted. Register storage and interrupt handling belong to the surrounding core.

Top module: `idec_npc_unit`

## Requirements
- R1: Field positions: group = instr[31:30], immediate flag = instr[29], operation = instr[28:26], A index = instr[25:21], B index = instr[20:16], immediate = instr[15:0], C index = instr[4:0]. Each field appears unchanged on its output.
- R2: When instr[29] is 1, operand C is the 16-bit immediate zero-extended. Otherwise operand C is the value of the register named by the C index.
- R3: A register index of 0 reads as zero for A, B and C, whatever value is driven on the matching value input.
- R4: For groups 0, 1 and 3 the next PC is the current PC + 1, modulo 2^PC_W. None of these groups raise link, extra-cycle, queue-enable or trap.
- R5: Flow operations 0 (A==B), 1 (A!=B), 3 (A<B) and 4 (A<=B) compare A and B as signed values. When the condition holds, the next PC is PC+1 plus the low PC_W bits of C, modulo 2^PC_W. Otherwise it is PC+1.
- R6: Flow operation 2 loads the next PC with the low PC_W bits of C when A==B. Otherwise the next PC is PC+1.
- R7: Flow operation 6 (call) raises the link write for register index 15 with link data PC+1. The target is PC+1+C when the immediate flag is 1, and C when it is 0.
- R8: Flow operation 7 sets the next PC to the low PC_W bits of the exception-return input and raises the interrupt-queue enable.
- R9: The extra-cycle flag is 1 exactly for a taken conditional branch or jump, a call, or an exception return.
- R10: Flow operation 5 raises the trap flag with cause 258. The next PC is PC+1 and there is no extra cycle.
- R11: Outputs are registered with one cycle of latency. o_valid follows i_valid one clock later, and reset clears o_valid, the next PC and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Instruction and operands present |
| i_instr | input | 32 | Instruction word |
| i_ra_val | input | DATA_W | Value of register named by A index |
| i_rb_val | input | DATA_W | Value of register named by B index |
| i_rc_val | input | DATA_W | Value of register named by C index |
| i_pc | input | PC_W | Current program counter |
| i_epc | input | DATA_W | Exception-return register value |
| o_valid | output | 1 | Results valid |
| o_grp | output | 2 | Instruction group |
| o_imm | output | 1 | Immediate flag |
| o_op | output | 3 | Operation |
| o_ra | output | 5 | A index |
| o_rb | output | 5 | B index |
| o_rc | output | 5 | C index |
| o_imm16 | output | 16 | Immediate field |
| o_npc | output | PC_W | Next program counter |
| o_link_we | output | 1 | Link register write request |
| o_link_idx | output | 5 | Link register index (15) |
| o_link_data | output | PC_W | Link value (PC+1) |
| o_extra_cycle | output | 1 | Instruction costs one extra cycle |
| o_iq_enable | output | 1 | Re-enable interrupt queue handling |
| o_exc | output | 1 | Trap request |
| o_exc_cause | output | CAUSE_W | Trap cause |

## Verification
The assertions check several properties on every cycle. They confirm the one-cycle valid latency and the incremented PC for non-flow groups. They confirm that link writes occur only for calls and carry PC+1, that the queue enable comes only with an exception-return extra cycle, that the extra-cycle flag stays inside the flow group, and that a trap carries cause 258 without an extra cycle. Only the bench scenarios can show the rest. These are the signed compare outcomes for negative operands, the wrap of relative targets past the top of the PC range, the zero reading of index 0, and the choice between immediate and register C, each of which needs specific operand values.

// File: rtl/idec_pkg.sv
package idec_pkg;
   localparam int INSTR_W = 32;
   localparam int RIDX_W  = 5;
   localparam int OP_W    = 3;
   localparam int IMM_W   = 16;

   typedef enum logic [1:0] {
      GRP_ALU  = 2'd0,
      GRP_XALU = 2'd1,
      GRP_FLOW = 2'd2,
      GRP_MOVE = 2'd3
   } grp_e;

   localparam logic [OP_W-1:0] FL_BEQ  = 3'd0;
   localparam logic [OP_W-1:0] FL_BNE  = 3'd1;
   localparam logic [OP_W-1:0] FL_JEQ  = 3'd2;
   localparam logic [OP_W-1:0] FL_BLT  = 3'd3;
   localparam logic [OP_W-1:0] FL_BLE  = 3'd4;
   localparam logic [OP_W-1:0] FL_TRAP = 3'd5;
   localparam logic [OP_W-1:0] FL_CALL = 3'd6;
   localparam logic [OP_W-1:0] FL_ERET = 3'd7;

   typedef struct packed {
      grp_e              grp;
      logic              imm;
      logic [OP_W-1:0]   op;
      logic [RIDX_W-1:0] ra;
      logic [RIDX_W-1:0] rb;
      logic [RIDX_W-1:0] rc;
      logic [IMM_W-1:0]  imm16;
   } fields_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
   import idec_pkg::*;
(
   input  logic [INSTR_W-1:0] i_instr,
   output fields_t            o_f
);
   // R1 field extraction
   assign o_f.grp   = grp_e'(i_instr[31:30]);
   assign o_f.imm   = i_instr[29];
   assign o_f.op    = i_instr[28:26];
   assign o_f.ra    = i_instr[25:21];
   assign o_f.rb    = i_instr[20:16];
   assign o_f.rc    = i_instr[4:0];
   assign o_f.imm16 = i_instr[15:0];
endmodule

// File: rtl/idec_operands.sv
module idec_operands
   import idec_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit ZERO_R0 = 1'b1
)(
   input  fields_t           i_f,
   input  logic [DATA_W-1:0] i_va,
   input  logic [DATA_W-1:0] i_vb,
   input  logic [DATA_W-1:0] i_vc,
   output logic [DATA_W-1:0] o_a,
   output logic [DATA_W-1:0] o_b,
   output logic [DATA_W-1:0] o_c
);
   localparam int NPORT = 3;

   if (DATA_W < IMM_W) begin : g_chk_w
      $error("DATA_W must hold the immediate");
   end

   logic [DATA_W-1:0] raw  [NPORT];
   logic [DATA_W-1:0] rd   [NPORT];
   logic [RIDX_W-1:0] idx  [NPORT];

   assign raw[0] = i_va;
   assign raw[1] = i_vb;
   assign raw[2] = i_vc;
   assign idx[0] = i_f.ra;
   assign idx[1] = i_f.rb;
   assign idx[2] = i_f.rc;

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      if (ZERO_R0) begin : g_z
         // R3 index zero reads zero
         assign rd[g] = (idx[g] == '0) ? '0 : raw[g];
      end else begin : g_nz
         assign rd[g] = raw[g];
      end
   end

   assign o_a = rd[0];
   assign o_b = rd[1];
   // R2 immediate replaces C
   assign o_c = i_f.imm ? DATA_W'(i_f.imm16) : rd[2];
endmodule

// File: rtl/idec_npc.sv
module idec_npc
   import idec_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PC_W      = 16,
   parameter int CAUSE_W   = 16,
   parameter int EXC_CAUSE = 258
)(
   input  grp_e              i_grp,
   input  logic [OP_W-1:0]   i_op,
   input  logic              i_imm,
   input  logic [DATA_W-1:0] i_a,
   input  logic [DATA_W-1:0] i_b,
   input  logic [DATA_W-1:0] i_c,
   input  logic [PC_W-1:0]   i_pc,
   input  logic [DATA_W-1:0] i_epc,
   output logic [PC_W-1:0]   o_npc,
   output logic              o_link_we,
   output logic [PC_W-1:0]   o_link_data,
   output logic              o_extra,
   output logic              o_iq_en,
   output logic              o_exc,
   output logic [CAUSE_W-1:0] o_cause
);
   if (PC_W > DATA_W || PC_W < 1) begin : g_chk_pc
      $error("PC_W must be between 1 and DATA_W");
   end
   if (EXC_CAUSE >= (1 << CAUSE_W)) begin : g_chk_cause
      $error("EXC_CAUSE does not fit CAUSE_W");
   end

   logic [PC_W-1:0] pc_inc, tgt_rel, tgt_abs;
   logic            eq, lt, cond;

   assign pc_inc  = i_pc + PC_W'(1);
   assign tgt_abs = i_c[PC_W-1:0];
   assign tgt_rel = pc_inc + tgt_abs;
   assign eq      = (i_a == i_b);
   assign lt      = ($signed(i_a) < $signed(i_b));

   always_comb begin
      unique case (i_op)
         FL_BEQ, FL_JEQ: cond = eq;
         FL_BNE:         cond = !eq;
         FL_BLT:         cond = lt;
         FL_BLE:         cond = lt || eq;
         default:        cond = 1'b0;
      endcase
   end

   always_comb begin
      o_npc       = pc_inc;
      o_link_we   = 1'b0;
      o_link_data = pc_inc;
      o_extra     = 1'b0;
      o_iq_en     = 1'b0;
      o_exc       = 1'b0;
      o_cause     = '0;
      if (i_grp == GRP_FLOW) begin
         unique case (i_op)
            FL_BEQ, FL_BNE, FL_BLT, FL_BLE: begin
               if (cond) begin
                  o_npc   = tgt_rel;
                  o_extra = 1'b1;
               end
            end
            FL_JEQ: begin
               if (cond) begin
                  o_npc   = tgt_abs;
                  o_extra = 1'b1;
               end
            end
            FL_TRAP: begin
               o_exc   = 1'b1;
               o_cause = CAUSE_W'(EXC_CAUSE);
            end
            FL_CALL: begin
               o_link_we = 1'b1;
               o_npc     = i_imm ? tgt_rel : tgt_abs;
               o_extra   = 1'b1;
            end
            default: begin
               o_npc   = i_epc[PC_W-1:0];
               o_iq_en = 1'b1;
               o_extra = 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/idec_npc_unit.sv
module idec_npc_unit
   import idec_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PC_W      = 16,
   parameter int CAUSE_W   = 16,
   parameter int EXC_CAUSE = 258,
   parameter int LINK_IDX  = 15,
   parameter bit ZERO_R0   = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                i_valid,
   input  logic [31:0]         i_instr,
   input  logic [DATA_W-1:0]   i_ra_val,
   input  logic [DATA_W-1:0]   i_rb_val,
   input  logic [DATA_W-1:0]   i_rc_val,
   input  logic [PC_W-1:0]     i_pc,
   input  logic [DATA_W-1:0]   i_epc,
   output logic                o_valid,
   output logic [1:0]          o_grp,
   output logic                o_imm,
   output logic [2:0]          o_op,
   output logic [4:0]          o_ra,
   output logic [4:0]          o_rb,
   output logic [4:0]          o_rc,
   output logic [15:0]         o_imm16,
   output logic [PC_W-1:0]     o_npc,
   output logic                o_link_we,
   output logic [4:0]          o_link_idx,
   output logic [PC_W-1:0]     o_link_data,
   output logic                o_extra_cycle,
   output logic                o_iq_enable,
   output logic                o_exc,
   output logic [CAUSE_W-1:0]  o_exc_cause
);
   if (LINK_IDX < 0 || LINK_IDX >= (1 << RIDX_W)) begin : g_chk_link
      $error("LINK_IDX out of range");
   end

   fields_t             f;
   logic [DATA_W-1:0]   op_a, op_b, op_c;
   logic [PC_W-1:0]     n_npc, n_ldata;
   logic                n_lwe, n_extra, n_iq, n_exc;
   logic [CAUSE_W-1:0]  n_cause;

   idec_fields u_fields (.i_instr(i_instr), .o_f(f));

   idec_operands #(.DATA_W(DATA_W), .ZERO_R0(ZERO_R0)) u_ops (
      .i_f(f), .i_va(i_ra_val), .i_vb(i_rb_val), .i_vc(i_rc_val),
      .o_a(op_a), .o_b(op_b), .o_c(op_c)
   );

   idec_npc #(.DATA_W(DATA_W), .PC_W(PC_W), .CAUSE_W(CAUSE_W),
              .EXC_CAUSE(EXC_CAUSE)) u_npc (
      .i_grp(f.grp), .i_op(f.op), .i_imm(f.imm),
      .i_a(op_a), .i_b(op_b), .i_c(op_c), .i_pc(i_pc), .i_epc(i_epc),
      .o_npc(n_npc), .o_link_we(n_lwe), .o_link_data(n_ldata),
      .o_extra(n_extra), .o_iq_en(n_iq), .o_exc(n_exc), .o_cause(n_cause)
   );

   assign o_link_idx = RIDX_W'(LINK_IDX);

   // R11 output register stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid       <= 1'b0;
         o_grp         <= '0;
         o_imm         <= 1'b0;
         o_op          <= '0;
         o_ra          <= '0;
         o_rb          <= '0;
         o_rc          <= '0;
         o_imm16       <= '0;
         o_npc         <= '0;
         o_link_we     <= 1'b0;
         o_link_data   <= '0;
         o_extra_cycle <= 1'b0;
         o_iq_enable   <= 1'b0;
         o_exc         <= 1'b0;
         o_exc_cause   <= '0;
      end else begin
         o_valid       <= i_valid;
         o_link_we     <= i_valid && n_lwe;
         o_extra_cycle <= i_valid && n_extra;
         o_iq_enable   <= i_valid && n_iq;
         o_exc         <= i_valid && n_exc;
         if (i_valid) begin
            o_grp       <= f.grp;
            o_imm       <= f.imm;
            o_op        <= f.op;
            o_ra        <= f.ra;
            o_rb        <= f.rb;
            o_rc        <= f.rc;
            o_imm16     <= f.imm16;
            o_npc       <= n_npc;
            o_link_data <= n_ldata;
            o_exc_cause <= n_cause;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (o_valid == $past(i_valid))); // R11
   AST_SEQ_NPC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && o_valid && o_grp != GRP_FLOW) |->
         (o_npc == PC_W'($past(i_pc) + PC_W'(1)))); // R4
   AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      o_link_we |-> (o_valid && o_grp == GRP_FLOW && o_op == FL_CALL)); // R7
   AST_LINK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && o_link_we) |->
         (o_link_data == PC_W'($past(i_pc) + PC_W'(1)))); // R7
   AST_ERET_IQ: assert property (@(posedge clk) disable iff (!rst_n)
      o_iq_enable |-> (o_extra_cycle && o_op == FL_ERET)); // R8
   AST_EXTRA_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      o_extra_cycle |-> (o_valid && o_grp == GRP_FLOW)); // R9
   AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      o_exc |-> (!o_extra_cycle && o_exc_cause == CAUSE_W'(EXC_CAUSE))); // R10
endmodule

// File: tb/sim_idec_npc_unit.sv
`timescale 1ns/1ps
module sim_idec_npc_unit;
   localparam int DW = 32;
   localparam int PW = 16;
   localparam int CW = 16;

   typedef struct packed {
      logic [1:0]  grp;
      logic        imm;
      logic [2:0]  op;
      logic [4:0]  ra, rb, rc;
      logic [15:0] imm16;
      logic [15:0] npc;
      logic        lwe;
      logic [4:0]  lidx;
      logic [15:0] ldata;
      logic        extra, iq, exc;
      logic [15:0] cause;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0, i_valid = 1'b0;
   logic [31:0] i_instr = '0;
   logic [DW-1:0] i_ra_val = '0, i_rb_val = '0, i_rc_val = '0, i_epc = '0;
   logic [PW-1:0] i_pc = '0;
   logic o_valid, o_imm, o_link_we, o_extra_cycle, o_iq_enable, o_exc;
   logic [1:0] o_grp;
   logic [2:0] o_op;
   logic [4:0] o_ra, o_rb, o_rc, o_link_idx;
   logic [15:0] o_imm16;
   logic [PW-1:0] o_npc, o_link_data;
   logic [CW-1:0] o_exc_cause;

   int checks = 0, fails = 0;
   bit done = 0;
   exp_t  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   idec_npc_unit u0 (.*);

   function automatic logic [31:0] mk(input logic [1:0] g, input logic im,
         input logic [2:0] op, input logic [4:0] ra, input logic [4:0] rb,
         input logic [15:0] imm16);
      return {g, im, op, ra, rb, imm16};
   endfunction

   function automatic exp_t model(input logic [31:0] w, input logic [31:0] va,
         input logic [31:0] vb, input logic [31:0] vc, input logic [15:0] pc,
         input logic [31:0] epc);
      exp_t e;
      logic [31:0] a, b, c;
      logic [15:0] nxt;
      logic t;
      e = '0;
      e.grp = w[31:30]; e.imm = w[29]; e.op = w[28:26];
      e.ra = w[25:21]; e.rb = w[20:16]; e.rc = w[4:0]; e.imm16 = w[15:0];
      e.lidx = 5'd15;
      a = (e.ra == 0) ? 32'd0 : va;
      b = (e.rb == 0) ? 32'd0 : vb;
      c = e.imm ? {16'd0, e.imm16} : ((e.rc == 0) ? 32'd0 : vc);
      nxt = pc + 16'd1;
      e.npc = nxt; e.ldata = nxt;
      if (e.grp == 2'd2) begin
         t = 1'b0;
         case (e.op)
            3'd0, 3'd2: t = (a == b);
            3'd1: t = (a != b);
            3'd3: t = ($signed(a) < $signed(b));
            3'd4: t = ($signed(a) <= $signed(b));
            default: t = 1'b0;
         endcase
         case (e.op)
            3'd2: if (t) begin e.npc = c[15:0]; e.extra = 1; end
            3'd5: begin e.exc = 1; e.cause = 16'd258; end
            3'd6: begin
               e.lwe = 1; e.extra = 1;
               e.npc = e.imm ? nxt + c[15:0] : c[15:0];
            end
            3'd7: begin e.npc = epc[15:0]; e.iq = 1; e.extra = 1; end
            default: if (t) begin e.npc = nxt + c[15:0]; e.extra = 1; end
         endcase
      end
      return e;
   endfunction

   task automatic send(input logic [31:0] w, input logic [31:0] va,
         input logic [31:0] vb, input logic [31:0] vc, input logic [15:0] pc,
         input logic [31:0] epc, input string tag);
      @(negedge clk);
      i_instr = w; i_ra_val = va; i_rb_val = vb; i_rc_val = vc;
      i_pc = pc; i_epc = epc; i_valid = 1'b1;
      exp_q.push_back(model(w, va, vb, vc, pc, epc));
      tag_q.push_back(tag);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
         input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && o_valid) begin
         exp_t  e, act;
         string t;
         act = {o_grp, o_imm, o_op, o_ra, o_rb, o_rc, o_imm16, o_npc,
                o_link_we, o_link_idx, o_link_data, o_extra_cycle,
                o_iq_enable, o_exc, o_exc_cause};
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11 unexpected valid", 64'd1, 64'd0);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (act !== e)
               $display("FAIL %s actual=%h expected=%h", t, act, e);
            checks++;
            if (act !== e) fails++;
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(o_valid == 0, "R11 reset valid", 64'(o_valid), 0);
      chk(o_npc == 0 && !o_extra_cycle && !o_link_we && !o_exc && !o_iq_enable,
          "R11 reset strobes", 64'(o_npc), 0);
      @(negedge clk); rst_n = 1'b1;

      send(mk(2'd0,0,3'd0,5'd3,5'd4,16'hA5C7), 1, 2, 3, 16'd100, 0, "R1 fields alu");
      send(mk(2'd3,0,3'd7,5'd9,5'd10,16'h0005), 1, 2, 3, 16'hFFFF, 0, "R4 move wrap");
      send(mk(2'd1,1,3'd5,5'd1,5'd2,16'h0010), 1, 2, 3, 16'd7, 0, "R4 xalu");
      send(mk(2'd2,1,3'd0,5'd1,5'd2,16'd10), 42, 42, 0, 16'd20, 0, "R5,R9 beq taken");
      send(mk(2'd2,1,3'd0,5'd1,5'd2,16'd10), 42, 43, 0, 16'd20, 0, "R5,R9 beq not");
      send(mk(2'd2,0,3'd1,5'd1,5'd2,16'h0003), 1, 2, 32'h0001_0005, 16'd20, 0, "R5 bne regC");
      send(mk(2'd2,1,3'd3,5'd1,5'd2,16'd8), 32'hFFFF_FFFF, 1, 0, 16'd30, 0, "R5 blt signed");
      send(mk(2'd2,1,3'd3,5'd1,5'd2,16'd8), 1, 32'hFFFF_FFFF, 0, 16'd30, 0, "R5 blt not");
      send(mk(2'd2,1,3'd4,5'd1,5'd2,16'd4), 32'h8000_0000, 32'h8000_0000, 0, 16'd30, 0, "R5 ble eq");
      send(mk(2'd2,1,3'd0,5'd1,5'd2,16'd3), 5, 5, 0, 16'hFFFF, 0, "R5 wrap");
      send(mk(2'd2,1,3'd2,5'd1,5'd2,16'h1234), 9, 9, 0, 16'd40, 0, "R6,R9 jeq taken");
      send(mk(2'd2,1,3'd2,5'd1,5'd2,16'h1234), 9, 8, 0, 16'd40, 0, "R6 jeq not");
      send(mk(2'd2,1,3'd6,5'd0,5'd0,16'd100), 0, 0, 0, 16'd50, 0, "R7 call rel");
      send(mk(2'd2,0,3'd6,5'd0,5'd0,16'h0007), 0, 0, 32'h00AB_0400, 16'd50, 0, "R7 call abs");
      send(mk(2'd2,0,3'd7,5'd0,5'd0,16'h0000), 0, 0, 0, 16'd60, 32'hDEAD_0123, "R8,R9 eret");
      send(mk(2'd2,0,3'd5,5'd1,5'd2,16'h0000), 1, 2, 0, 16'd70, 0, "R10 trap");
      send(mk(2'd2,1,3'd0,5'd0,5'd0,16'd6), 5, 7, 0, 16'd80, 0, "R3 zero A B");
      send(mk(2'd2,0,3'd6,5'd0,5'd0,16'h0000), 0, 0, 32'h0777, 16'd90, 0, "R3 zero C");
      send(mk(2'd2,1,3'd2,5'd1,5'd2,16'h0003), 4, 4, 32'h9999, 16'd1, 0, "R2 imm C");
      send(mk(2'd2,0,3'd2,5'd1,5'd2,16'h0003), 4, 4, 32'h9999, 16'd1, 0, "R2 reg C");
      @(negedge clk); i_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R11 valid drops with input
      chk(o_valid == 0, "R11 idle valid", 64'(o_valid), 0);
      chk(exp_q.size() == 0, "R11 all results seen", 64'(exp_q.size()), 0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule